// File: doc/BRIEF.md
# 32-bit ALU with Registered Condition Flags

This block combines a single-cycle integer arithmetic and logic datapath with a six-bit register that holds its condition flags. Two 32-bit operands and a 3-bit operation code produce a result in the same cycle. When the update enable is high, the flags that the operation produces are captured on the next rising clock edge. The stored carry flag feeds back as the incoming carry for the add-with-carry and subtract-with-borrow operations, so wide additions and subtractions can be chained over several cycles.

Software-style flag writes arrive as per-bit set and clear masks. A bit named in either mask takes the requested value on the next edge, and this overrides whatever the ALU produces for that bit in the same cycle. Bits not named in either mask follow the normal update rule. The result output is combinational. The flags output comes directly from the register.

Top module: `alu_status_core`

## Requirements
- R1: `op_sel` selects the operation as follows. 0 is A+B, 1 is A+B+Cf, 2 is A-B, 3 is A-B-Cf, 4 is A AND B, 5 is A OR B, 6 is A XOR B and 7 passes B. Cf is the stored carry flag. `result` shows the low 32 bits in the same cycle.
- R2: For codes 0 to 3, the new carry flag is the carry out of bit 31 on addition. On subtraction it is the borrow, meaning the unsigned value of A is smaller than B plus the incoming borrow.
- R3: For codes 0 to 3, the new overflow flag is 1 exactly when the true signed result lies outside the range -2^31 to 2^31-1.
- R4: For every operation, the new zero flag is 1 when all 32 result bits are 0. The new sign flag equals result bit 31.
- R5: For codes 0 to 3, the new auxiliary flag is the carry (on add) or borrow (on subtract) out of the low 4-bit nibble into bit 4.
- R6: The new parity flag is 1 when result bits 7..0 hold an even number of ones. Bits 31..8 have no effect on it.
- R7: For codes 4 to 7, the new carry, auxiliary and overflow flags are 0.
- R8: `flags` packs the flags as carry in bit 0, parity in bit 1, auxiliary in bit 2, zero in bit 3, sign in bit 4 and overflow in bit 5. It changes only on a rising clock edge. Without `upd_en` and without set or clear requests, it holds its value.
- R9: A 1 in `flag_set[i]` forces flag i to 1 on the next edge. Otherwise a 1 in `flag_clr[i]` forces it to 0. Either request overrides the ALU update for that bit only. Set wins over clear.
- R10: With `rst` high at a rising edge, all six flags become 0. Reset takes priority over set requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| upd_en | input | 1 | Capture ALU flags on the next edge |
| flag_set | input | 6 | Per-flag set requests |
| flag_clr | input | 6 | Per-flag clear requests |
| result | output | 32 | Combinational result |
| flags | output | 6 | Registered flag word |

## Verification
A wrong value in the flag register is visible on `flags` one edge after the faulty update. Because the stored carry feeds back into the datapath, a stale or wrong carry also shows up on `result` as soon as the next operation with code 1 or 3 is applied. For that reason the bench compares both the result and every flag bit against its model on every cycle, and it repeats chained carry and borrow operations after hold, set and clear cycles.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SBB   = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_XOR   = 3'd6,
    OP_PASSB = 3'd7
  } alu_op_e;

  localparam int NFLAGS = 6;

  // Packed order places cry at bit 0 and ovf at bit 5.
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flag_word_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32,
  parameter int NIB   = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             use_cin,
  input  logic             cf_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_flag,
  output logic             aux_flag,
  output logic             ovf_flag
);
  localparam int MIDW = WIDTH - 1 - NIB;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [NIB-1:0]   s_lo;
  logic             c_lo;
  logic [MIDW-1:0]  s_mid;
  logic             c_msb;
  logic             s_top;
  logic             c_out;

  always_comb begin
    b_eff = sub ? ~b : b;
    cin   = sub ? ~(use_cin & cf_in) : (use_cin & cf_in);
  end

  // Low nibble: its carry out gives the auxiliary flag.
  always_comb begin
    {c_lo, s_lo} = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin};
  end

  // Middle bits: the carry out is the carry into the sign bit.
  always_comb begin
    {c_msb, s_mid} = {1'b0, a[WIDTH-2:NIB]} + {1'b0, b_eff[WIDTH-2:NIB]}
                   + {{MIDW{1'b0}}, c_lo};
  end

  // Sign bit is kept separate so that overflow is a simple XOR of the two carries.
  always_comb begin
    s_top = a[WIDTH-1] ^ b_eff[WIDTH-1] ^ c_msb;
    c_out = (a[WIDTH-1] & b_eff[WIDTH-1]) | (c_msb & (a[WIDTH-1] ^ b_eff[WIDTH-1]));
  end

  always_comb begin
    sum        = {s_top, s_mid, s_lo};
    carry_flag = sub ? ~c_out : c_out;
    aux_flag   = sub ? ~c_lo  : c_lo;
    ovf_flag   = c_msb ^ c_out;
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       fn,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int PBITS = 8
) (
  input  logic [WIDTH-1:0] res,
  input  logic             is_arith,
  input  logic             cry_in,
  input  logic             aux_in,
  input  logic             ovf_in,
  output flag_word_t       fw
);
  logic [PBITS:0] par_chain;

  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < PBITS; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res[i];
  end

  always_comb begin
    fw.cry = is_arith & cry_in;
    fw.aux = is_arith & aux_in;
    fw.ovf = is_arith & ovf_in;
    fw.par = par_chain[PBITS];
    fw.zro = (res == '0);
    fw.sgn = res[WIDTH-1];
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [NF-1:0] nxt,
  input  logic [NF-1:0] set_req,
  input  logic [NF-1:0] clr_req,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             q[i] <= 1'b0;
      else if (set_req[i]) q[i] <= 1'b1;
      else if (clr_req[i]) q[i] <= 1'b0;
      else if (upd_en)     q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int NIB   = 4,
  parameter int PBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  input  logic             upd_en,
  input  logic [5:0]       flag_set,
  input  logic [5:0]       flag_clr,
  output logic [WIDTH-1:0] result,
  output logic [5:0]       flags
);
  alu_op_e          op;
  logic             is_arith;
  logic [WIDTH-1:0] as_sum, lg_y;
  logic             as_cry, as_aux, as_ovf;
  flag_word_t       fw_next, fw_q;
  logic [NFLAGS-1:0] q_bits;

  always_comb begin
    op       = alu_op_e'(op_sel);
    is_arith = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB});
  end

  alu_addsub #(.WIDTH(WIDTH), .NIB(NIB)) u_addsub (
    .a(op_a), .b(op_b),
    .sub(op_sel[1]), .use_cin(op_sel[0]), .cf_in(fw_q.cry),
    .sum(as_sum), .carry_flag(as_cry), .aux_flag(as_aux), .ovf_flag(as_ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(op_a), .b(op_b), .fn(op_sel[1:0]), .y(lg_y)
  );

  always_comb result = is_arith ? as_sum : lg_y;

  alu_flag_eval #(.WIDTH(WIDTH), .PBITS(PBITS)) u_eval (
    .res(result), .is_arith(is_arith),
    .cry_in(as_cry), .aux_in(as_aux), .ovf_in(as_ovf),
    .fw(fw_next)
  );

  alu_flag_reg #(.NF(NFLAGS)) u_freg (
    .clk(clk), .rst(rst), .upd_en(upd_en),
    .nxt(fw_next), .set_req(flag_set), .clr_req(flag_clr),
    .q(q_bits)
  );

  always_comb begin
    fw_q  = flag_word_t'(q_bits);
    flags = q_bits;
  end

endmodule

// File: rtl/alu_status_core_chk.sv
module alu_status_core_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       op_sel,
  input logic             upd_en,
  input logic [5:0]       flag_set,
  input logic [5:0]       flag_clr,
  input logic [WIDTH-1:0] result,
  input logic [5:0]       flags
);
  logic quiet_upd, idle;
  assign quiet_upd = upd_en && (flag_set == '0) && (flag_clr == '0);
  assign idle      = !upd_en && (flag_set == '0) && (flag_clr == '0);

  a_r10_reset_clears: assert property (@(posedge clk) rst |=> flags == 6'd0);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(flags));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

  a_r9_clear_applies: assert property (@(posedge clk) disable iff (rst)
    ((flag_clr & ~flag_set) != '0) |=> ((flags & $past(flag_clr & ~flag_set)) == 6'd0));

  a_r7_logic_no_carry: assert property (@(posedge clk) disable iff (rst)
    (quiet_upd && op_sel[2]) |=> (flags[0] == 1'b0 && flags[2] == 1'b0 && flags[5] == 1'b0));

  a_r4_zero_sign: assert property (@(posedge clk) disable iff (rst)
    quiet_upd |=> (flags[3] == ($past(result) == '0)) && (flags[4] == $past(result[WIDTH-1])));

  a_r6_low_byte_parity: assert property (@(posedge clk) disable iff (rst)
    quiet_upd |=> flags[1] == ~^$past(result[7:0]));

  a_r1_pass_b: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd7) |-> result == op_b);

  a_r1_xor_op: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd6) |-> result == (op_a ^ op_b));

endmodule

bind alu_status_core alu_status_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .upd_en(upd_en), .flag_set(flag_set), .flag_clr(flag_clr),
  .result(result), .flags(flags)
);

// File: tb/alu_status_core_tb_top.sv
module alu_status_core_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b, result;
  logic [2:0]  op_sel;
  logic        upd_en;
  logic [5:0]  flag_set, flag_clr, flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Model state
  logic [5:0] ref_flags;
  bit         prv_rst;
  bit         prv_upd;
  bit         prv_logic;
  logic [5:0] prv_req;

  always #5 clk = ~clk;

  alu_status_core dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .upd_en(upd_en), .flag_set(flag_set), .flag_clr(flag_clr),
    .result(result), .flags(flags)
  );

  function automatic string bit_tag(int i);
    if (prv_rst) return "R10";
    if (prv_req[i]) return "R9";
    if (!prv_upd) return "R8";
    if (prv_logic && (i == 0 || i == 2 || i == 5)) return "R7";
    case (i)
      0: return "R2";
      1: return "R6";
      2: return "R5";
      5: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Behavioural reference: returns result and the flags the ALU would produce
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic cf, output logic [31:0] r, output logic [5:0] f);
    longint ua, ub, ci, s, sa, sb, ss;
    bit c, ac, ov, pr;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ci = (op == 3'd1 || op == 3'd3) ? longint'(cf) : 0;
    c = 0; ac = 0; ov = 0;
    case (op)
      3'd0, 3'd1: begin
        s  = ua + ub + ci;
        r  = s[31:0];
        c  = (s > 64'sd4294967295);
        ac = ((ua % 16) + (ub % 16) + ci) > 15;
        ss = sa + sb + ci;
        ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd2, 3'd3: begin
        s  = ua - ub - ci;
        r  = s[31:0];
        c  = ua < (ub + ci);
        ac = (ua % 16) < ((ub % 16) + ci);
        ss = sa - sb - ci;
        ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd4: r = a & b;
      3'd5: r = a | b;
      3'd6: r = a ^ b;
      default: r = b;
    endcase
    pr = 1;
    for (int i = 0; i < 8; i++) if (r[i]) pr = !pr;
    f = {ov, r[31], (r == 32'd0), ac, pr, c};
  endtask

  task automatic step(input bit r_in, input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] b, input bit u, input logic [5:0] s,
                      input logic [5:0] c);
    logic [31:0] exp_r;
    logic [5:0]  exp_f;
    @(negedge clk);
    rst = r_in; op_sel = op; op_a = a; op_b = b; upd_en = u; flag_set = s; flag_clr = c;
    #2;
    // Registered flags from the previous edge
    for (int i = 0; i < 6; i++) begin
      checks++;
      if (flags[i] !== ref_flags[i]) begin
        failures++;
        $display("FAIL %s flag bit %0d: actual %b expected %b", bit_tag(i), i, flags[i], ref_flags[i]);
      end
    end
    model(op, a, b, ref_flags[0], exp_r, exp_f);
    checks++;
    if (result !== exp_r) begin
      failures++;
      $display("FAIL R1 op %0d result: actual %h expected %h", op, result, exp_r);
    end
    // Next model state
    for (int i = 0; i < 6; i++) begin
      if (r_in) ref_flags[i] = 1'b0;
      else if (s[i]) ref_flags[i] = 1'b1;
      else if (c[i]) ref_flags[i] = 1'b0;
      else if (u) ref_flags[i] = exp_f[i];
    end
    prv_rst = r_in; prv_upd = u; prv_logic = op[2]; prv_req = s | c;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; op_sel = 0; op_a = 0; op_b = 0; upd_en = 0; flag_set = 0; flag_clr = 0;
    ref_flags = 6'd0; prv_rst = 1; prv_upd = 0; prv_logic = 0; prv_req = 0;
    repeat (2) @(posedge clk);
    // R10 reset state
    step(1, 3'd0, 0, 0, 0, 0, 0);
    // R2 carry, R4 zero: 0xFFFFFFFF + 1
    step(0, 3'd0, 32'hFFFF_FFFF, 32'd1, 1, 0, 0);
    // R3 signed overflow on add, R5 aux from 0xF+1
    step(0, 3'd0, 32'h7FFF_FFFF, 32'd1, 1, 0, 0);
    step(0, 3'd0, 32'h0000_000F, 32'd1, 1, 0, 0);
    // R2 borrow 0-1, then R1 SBB chain uses stored borrow
    step(0, 3'd2, 32'd0, 32'd1, 1, 0, 0);
    step(0, 3'd3, 32'd10, 32'd3, 1, 0, 0);
    // R3 overflow on subtract: min - 1
    step(0, 3'd2, 32'h8000_0000, 32'd1, 1, 0, 0);
    // ADC with carry in from a carrying add
    step(0, 3'd0, 32'h8000_0000, 32'h8000_0000, 1, 0, 0);
    step(0, 3'd1, 32'd5, 32'd6, 1, 0, 0);
    // R6 parity ignores upper bytes
    step(0, 3'd7, 32'd0, 32'hFFFF_FF00, 1, 0, 0);
    step(0, 3'd7, 32'd0, 32'h0000_0100, 1, 0, 0);
    step(0, 3'd7, 32'd0, 32'h0000_0001, 1, 0, 0);
    // R7 logic ops after carry set
    step(0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0);
    step(0, 3'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, 1, 0, 0);
    step(0, 3'd5, 32'h8000_0000, 32'd3, 1, 0, 0);
    step(0, 3'd6, 32'h1234_5678, 32'h1234_5678, 1, 0, 0);
    // R8 hold without enable
    step(0, 3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0);
    step(0, 3'd2, 32'd0, 32'd9, 0, 0, 0);
    // R9 set all, clear some with ALU update, set beats clear
    step(0, 3'd0, 32'd1, 32'd1, 0, 6'h3F, 0);
    step(0, 3'd0, 32'd1, 32'd1, 1, 0, 6'h05);
    step(0, 3'd4, 32'd0, 32'd0, 1, 6'h21, 6'h21);
    step(0, 3'd1, 32'd0, 32'd0, 1, 0, 0);
    // R10 reset beats set
    step(1, 3'd0, 0, 0, 1, 6'h3F, 0);
    step(0, 3'd0, 0, 0, 0, 0, 0);
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb;
      logic [5:0]  rs, rc;
      ra = $urandom; rb = $urandom;
      if ($urandom % 4 == 0) rb = ra;
      if ($urandom % 8 == 0) ra = ra & 32'h8000_000F;
      rs = ($urandom % 6 == 0) ? 6'($urandom) : 6'd0;
      rc = ($urandom % 6 == 0) ? 6'($urandom) : 6'd0;
      step(($urandom % 200) == 0, 3'($urandom), ra, rb, ($urandom % 5) != 0, rs, rc);
    end
    step(0, 3'd0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule